// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

This block turns a set of wired interrupt lines, numbered 1 to N, into pending and enable state for an interrupt domain. Every source has its own configuration word that either hands the line to a child domain or picks a trigger mode: detached, rising edge, falling edge, active-high level or active-low level. Raw lines first pass a two-flop synchroniser. A registered copy of the synchronised level provides edge detection. Pending is then set according to the selected mode.

Software reaches the state through a single-cycle word register port. It can write and read the configuration words. It can set or clear pending and enable bits, either as 32-bit bitmaps or by source number. A further set-pending-by-number register takes its operand byte-reversed. Software pending writes are filtered by trigger mode and by the domain's delivery mode (`msi_mode_i`). A claim strobe that carries a source number clears that source's pending bit. For a level source, the claim sets pending again at once while the line remains active. The pending, enable and synchronised input vectors are brought out for the priority and delivery logic that follows.

Register map (word addresses on `reg_addr_i`):
- 1..N: configuration of source n.
- 0x20: pending bitmap, set on write.
- 0x21: reads the input levels, clears pending on write.
- 0x22: enable bitmap, set on write.
- 0x23: clears enables on write, reads 0.
- 0x24: sets pending by number.
- 0x25: clears pending by number.
- 0x26: sets enable by number.
- 0x27: clears enable by number.
- 0x28: sets pending by byte-reversed number.

All other addresses, and every by-number address, read as 0.

Top module: `irq_gateway`

## Requirements
- R1: The configuration word keeps bit 10 as the delegate flag. When the flag is set, the word stores the flag and the child index in bits 9:0. Otherwise it stores bit 10 clear and the trigger mode in bits 2:0, and all other bits read 0. The mode codes are 0 off, 1 detached, 4 rising, 5 falling, 6 high level and 7 low level. The pending bitmap reads at 0x20, the synchronised input levels at 0x21 and the enables at 0x22. Address 0x23 and every by-number address read 0.
- R2: When NUM_CHILD is 0, a configuration write with bit 10 set stores zero.
- R3: A configuration write whose stored result is zero, or that has the delegate flag set, clears that source's pending and enable bits on the same edge.
- R4: A rising (falling) source sets pending on a low-to-high (high-to-low) transition of its input. Pending is visible on the third clock edge after the raw line changes. A steady input sets nothing.
- R5: A high-level (low-level) source sets pending on every cycle in which its synchronised input is high (low). Software cannot clear its pending bit in direct mode.
- R6: Software set or clear of pending or enable is ignored for a source that is delegated or whose mode is 0, 2 or 3. Modes 2 and 3 detect nothing on the input.
- R7: For level modes with `msi_mode_i` low, software pending writes are ignored. With `msi_mode_i` high, software may set a level source's pending bit but cannot clear it.
- R8: A claim of source n clears its pending bit. For a level source whose synchronised input is still active, pending stays set.
- R9: Bitmap bit 0 and bits above N read 0, and writes to those bits have no effect. By-number writes with value 0 or above N are ignored.
- R10: A write to 0x28 reverses the byte order of the data and then sets pending for the resulting source number.
- R11: When a hardware pending set and a software pending clear fall on the same edge, pending ends up set.
- R12: After reset, all pending, enable, level and configuration state reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msi_mode_i | input | 1 | Domain delivers by message when high, directly when low |
| irq_raw_i | input | NUM_SRC | Raw interrupt lines for sources 1..N |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| claim_valid_i | input | 1 | Claim strobe |
| claim_id_i | input | 5 | Claimed source number |
| pend_o | output | NUM_SRC+1 | Pending vector, bit 0 always 0 |
| en_o | output | NUM_SRC+1 | Enable vector, bit 0 always 0 |
| level_o | output | NUM_SRC+1 | Synchronised input levels, bit 0 always 0 |

## Verification
The hardest case to reach is an edge detected by hardware on the exact edge where a software clear lands. The input path has three registers of latency, so the stimulus raises the line, counts two falling clock edges, and only then presents the clear write. This makes both requests meet at the third rising edge. The level re-arm on claim is reached in a similar way: the line is held high across the claim, and the bench checks that pending is still set before the line is dropped and a second claim finally clears it.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;
  localparam int ADDR_W  = 6;
  localparam int CFG_W   = 11;
  localparam int DLG_BIT = 10;
  localparam int ID_W    = 5;

  typedef enum logic [2:0] {
    TRIG_OFF    = 3'd0,
    TRIG_DETACH = 3'd1,
    TRIG_RISE   = 3'd4,
    TRIG_FALL   = 3'd5,
    TRIG_HIGH   = 3'd6,
    TRIG_LOW    = 3'd7
  } trig_e;

  localparam logic [ADDR_W-1:0] A_PEND_SET  = 6'h20;
  localparam logic [ADDR_W-1:0] A_PEND_CLR  = 6'h21;
  localparam logic [ADDR_W-1:0] A_EN_SET    = 6'h22;
  localparam logic [ADDR_W-1:0] A_EN_CLR    = 6'h23;
  localparam logic [ADDR_W-1:0] A_NUM_PSET  = 6'h24;
  localparam logic [ADDR_W-1:0] A_NUM_PCLR  = 6'h25;
  localparam logic [ADDR_W-1:0] A_NUM_ESET  = 6'h26;
  localparam logic [ADDR_W-1:0] A_NUM_ECLR  = 6'h27;
  localparam logic [ADDR_W-1:0] A_NUM_PSWAP = 6'h28;

  function automatic logic [31:0] byte_rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/irqgw_in_sync.sv
module irqgw_in_sync #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irqgw_cfg_bank.sv
module irqgw_cfg_bank
  import irqgw_pkg::*;
#(
  parameter int NUM_SRC   = 31,
  parameter int NUM_CHILD = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [ID_W-1:0]           wr_idx_i,
  input  logic [CFG_W-1:0]          wdata_i,
  output logic [NUM_SRC:1][CFG_W-1:0] cfg_o,
  output logic [NUM_SRC:1]          kill_o
);
  localparam bit HAS_CHILD = (NUM_CHILD > 0);

  logic [CFG_W-1:0] shaped;

  always_comb begin
    if (wdata_i[DLG_BIT] && HAS_CHILD) begin
      shaped = {1'b1, wdata_i[9:0]};
    end else if (wdata_i[DLG_BIT]) begin
      shaped = '0;
    end else begin
      shaped = {8'b0, wdata_i[2:0]};
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_ce;

    always_comb begin
      cfg_ce = wr_en_i && (wr_idx_i == ID_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_ce) begin
        cfg_q <= shaped;
      end
    end

    assign cfg_o[s]  = cfg_q;
    assign kill_o[s] = cfg_ce && ((shaped == '0) || shaped[DLG_BIT]);
  end
endmodule

// File: rtl/irqgw_src_slice.sv
module irqgw_src_slice
  import irqgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dlg_i,
  input  logic [2:0] mode_i,
  input  logic       kill_i,
  input  logic       lvl_i,
  input  logic       prev_i,
  input  logic       msi_i,
  input  logic       sw_pset_i,
  input  logic       sw_pclr_i,
  input  logic       sw_eset_i,
  input  logic       sw_eclr_i,
  input  logic       claim_i,
  output logic       pend_o,
  output logic       en_o
);
  logic pend_q, en_q, pend_d, en_d, pend_ce, en_ce;
  logic is_rise, is_fall, is_high, is_low, is_lvl, active;
  logic hw_set, pset_ok, pclr_ok;

  always_comb begin
    is_rise = !dlg_i && (mode_i == TRIG_RISE);
    is_fall = !dlg_i && (mode_i == TRIG_FALL);
    is_high = !dlg_i && (mode_i == TRIG_HIGH);
    is_low  = !dlg_i && (mode_i == TRIG_LOW);
    is_lvl  = is_high || is_low;
    active  = is_rise || is_fall || is_lvl || (!dlg_i && (mode_i == TRIG_DETACH));

    hw_set  = (is_rise && lvl_i && !prev_i) || (is_fall && !lvl_i && prev_i) ||
              (is_high && lvl_i) || (is_low && !lvl_i);
    pset_ok = sw_pset_i && active && (!is_lvl || msi_i);
    pclr_ok = sw_pclr_i && active && !is_lvl;

    pend_ce = kill_i || hw_set || pset_ok || pclr_ok || claim_i;
    if (kill_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = hw_set || pset_ok || (pend_q && !pclr_ok && !claim_i);
    end

    en_ce = kill_i || (active && (sw_eset_i || sw_eclr_i));
    if (kill_i) begin
      en_d = 1'b0;
    end else begin
      en_d = sw_eset_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
  import irqgw_pkg::*;
#(
  parameter int NUM_SRC   = 31,
  parameter int NUM_CHILD = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_mode_i,
  input  logic [NUM_SRC:1]   irq_raw_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               claim_valid_i,
  input  logic [ID_W-1:0]    claim_id_i,
  output logic [NUM_SRC:0]   pend_o,
  output logic [NUM_SRC:0]   en_o,
  output logic [NUM_SRC:0]   level_o
);
  logic rst_s1_q, rst_core_n;
  logic [NUM_SRC:1] lvl_w, prev_w, pend_w, en_w, kill_w;
  logic [NUM_SRC:1] pset_w, pclr_w, eset_w, eclr_w, claim_w;
  logic [NUM_SRC:1][CFG_W-1:0] cfg_w;
  logic        cfg_wr;
  logic [31:0] swapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  irqgw_in_sync #(.W(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .raw_i  (irq_raw_i),
    .lvl_o  (lvl_w),
    .prev_o (prev_w)
  );

  always_comb begin
    cfg_wr = reg_we_i && (reg_addr_i != '0) && (reg_addr_i <= ADDR_W'(NUM_SRC));
  end

  irqgw_cfg_bank #(.NUM_SRC(NUM_SRC), .NUM_CHILD(NUM_CHILD)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en_i  (cfg_wr),
    .wr_idx_i (reg_addr_i[ID_W-1:0]),
    .wdata_i  (reg_wdata_i[CFG_W-1:0]),
    .cfg_o    (cfg_w),
    .kill_o   (kill_w)
  );

  always_comb begin
    swapped = byte_rev(reg_wdata_i);
    for (int s = 1; s <= NUM_SRC; s++) begin
      pset_w[s]  = reg_we_i && (((reg_addr_i == A_PEND_SET) && reg_wdata_i[s]) ||
                                ((reg_addr_i == A_NUM_PSET) && (reg_wdata_i == 32'(s))) ||
                                ((reg_addr_i == A_NUM_PSWAP) && (swapped == 32'(s))));
      pclr_w[s]  = reg_we_i && (((reg_addr_i == A_PEND_CLR) && reg_wdata_i[s]) ||
                                ((reg_addr_i == A_NUM_PCLR) && (reg_wdata_i == 32'(s))));
      eset_w[s]  = reg_we_i && (((reg_addr_i == A_EN_SET) && reg_wdata_i[s]) ||
                                ((reg_addr_i == A_NUM_ESET) && (reg_wdata_i == 32'(s))));
      eclr_w[s]  = reg_we_i && (((reg_addr_i == A_EN_CLR) && reg_wdata_i[s]) ||
                                ((reg_addr_i == A_NUM_ECLR) && (reg_wdata_i == 32'(s))));
      claim_w[s] = claim_valid_i && (claim_id_i == ID_W'(s));
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_slice
    irqgw_src_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .dlg_i     (cfg_w[s][DLG_BIT]),
      .mode_i    (cfg_w[s][2:0]),
      .kill_i    (kill_w[s]),
      .lvl_i     (lvl_w[s]),
      .prev_i    (prev_w[s]),
      .msi_i     (msi_mode_i),
      .sw_pset_i (pset_w[s]),
      .sw_pclr_i (pclr_w[s]),
      .sw_eset_i (eset_w[s]),
      .sw_eclr_i (eclr_w[s]),
      .claim_i   (claim_w[s]),
      .pend_o    (pend_w[s]),
      .en_o      (en_w[s])
    );
  end

  assign pend_o  = {pend_w, 1'b0};
  assign en_o    = {en_w, 1'b0};
  assign level_o = {lvl_w, 1'b0};

  always_comb begin
    reg_rdata_o = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (reg_addr_i == ADDR_W'(s)) reg_rdata_o[CFG_W-1:0] = cfg_w[s];
    end
    if (reg_addr_i == A_PEND_SET) reg_rdata_o[NUM_SRC:0] = {pend_w, 1'b0};
    if (reg_addr_i == A_PEND_CLR) reg_rdata_o[NUM_SRC:0] = {lvl_w, 1'b0};
    if (reg_addr_i == A_EN_SET)   reg_rdata_o[NUM_SRC:0] = {en_w, 1'b0};
  end
endmodule

// File: rtl/irqgw_checker.sv
module irqgw_checker
  import irqgw_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_we_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic [NUM_SRC:0]            pend_o,
  input logic [NUM_SRC:0]            en_o,
  input logic [NUM_SRC:0]            level_o,
  input logic [NUM_SRC:1][CFG_W-1:0] cfg_w
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_SRC0_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[0] && !en_o[0] && !level_o[0]); // R9

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_chk
    AST_CFG_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_w[s][DLG_BIT] |-> (cfg_w[s][9:3] == '0)); // R1

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_w[s] == '0) || cfg_w[s][DLG_BIT]) |-> (!pend_o[s] && !en_o[s])); // R3

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ((cfg_w[s] == 11'(TRIG_RISE)) && level_o[s] && !$past(level_o[s]) &&
       !(reg_we_i && (reg_addr_i == ADDR_W'(s)))) |=> pend_o[s]); // R4

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((((cfg_w[s] == 11'(TRIG_HIGH)) && level_o[s]) ||
        ((cfg_w[s] == 11'(TRIG_LOW)) && !level_o[s])) &&
       !(reg_we_i && (reg_addr_i == ADDR_W'(s)))) |=> pend_o[s]); // R8
  end
endmodule

bind irq_gateway irqgw_checker #(.NUM_SRC(NUM_SRC)) u_irqgw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .pend_o     (pend_o),
  .en_o       (en_o),
  .level_o    (level_o),
  .cfg_w      (cfg_w)
);

// File: tb/test_irq_gateway.sv
module test_irq_gateway;
  localparam int NS = 20;

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 6'h03, 32'h0000_0004, 8'd1},   // R1 rising mode
    '{1'b0, 6'h03, 32'h0000_0004, 8'd1},
    '{1'b1, 6'h04, 32'h0000_0406, 8'd1},   // R1 delegated, child 6
    '{1'b0, 6'h04, 32'h0000_0406, 8'd1},
    '{1'b1, 6'h06, 32'h0000_F3FE, 8'd1},   // R1 extra bits dropped, high level
    '{1'b0, 6'h06, 32'h0000_0006, 8'd1},
    '{1'b1, 6'h07, 32'h0000_0001, 8'd1},   // R1 detached
    '{1'b0, 6'h07, 32'h0000_0001, 8'd1},
    '{1'b1, 6'h22, 32'hFFFF_FFFF, 8'd6},   // R6 enables only on active sources
    '{1'b0, 6'h22, 32'h0000_00C8, 8'd6},
    '{1'b1, 6'h20, 32'hFFFF_FFFF, 8'd7},   // R7 level source ignored in direct mode
    '{1'b0, 6'h20, 32'h0000_0088, 8'd7},
    '{1'b1, 6'h25, 32'h0000_0003, 8'd9},   // R9 clear by number
    '{1'b0, 6'h20, 32'h0000_0080, 8'd9},
    '{1'b1, 6'h27, 32'h0000_0007, 8'd9},
    '{1'b0, 6'h22, 32'h0000_0048, 8'd9},
    '{1'b1, 6'h26, 32'h0000_0004, 8'd6},   // R6 delegated source ignores enable
    '{1'b0, 6'h22, 32'h0000_0048, 8'd6},
    '{1'b1, 6'h03, 32'h0000_0000, 8'd3},   // R3 zero config kills enable
    '{1'b0, 6'h22, 32'h0000_0040, 8'd3},
    '{1'b1, 6'h07, 32'h0000_0000, 8'd3},   // R3 zero config kills pending
    '{1'b0, 6'h20, 32'h0000_0000, 8'd3},
    '{1'b0, 6'h23, 32'h0000_0000, 8'd1},   // R1 write-only address reads 0
    '{1'b0, 6'h21, 32'h0000_0000, 8'd1}
  };

  logic          clk, rst_n, msi, we, cv, we2;
  logic [NS:1]   raw;
  logic [5:0]    addr, addr2;
  logic [31:0]   wdata, rdata, wdata2, rdata2;
  logic [4:0]    cid;
  logic [NS:0]   pend, en, lvl;
  logic [4:0]    pend2, en2, lvl2;
  int            errors, checks;
  logic          done;
  logic [31:0]   d;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  irq_gateway #(.NUM_SRC(NS), .NUM_CHILD(1)) i_irq_gateway (
    .clk(clk), .rst_n(rst_n), .msi_mode_i(msi), .irq_raw_i(raw),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .claim_valid_i(cv), .claim_id_i(cid), .pend_o(pend), .en_o(en), .level_o(lvl)
  );

  irq_gateway #(.NUM_SRC(4), .NUM_CHILD(0)) i_irq_gateway_nochild (
    .clk(clk), .rst_n(rst_n), .msi_mode_i(1'b0), .irq_raw_i(4'b0),
    .reg_we_i(we2), .reg_addr_i(addr2), .reg_wdata_i(wdata2), .reg_rdata_o(rdata2),
    .claim_valid_i(1'b0), .claim_id_i(5'd0), .pend_o(pend2), .en_o(en2), .level_o(lvl2)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic claim(input logic [4:0] id);
    @(negedge clk);
    cv = 1'b1; cid = id;
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; msi = 1'b0; we = 1'b0; cv = 1'b0; cid = '0;
    raw = '0; addr = '0; wdata = '0; we2 = 1'b0; addr2 = '0; wdata2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(12, 32'(pend), 32'h0);
    chk(12, 32'(en), 32'h0);
    chk(12, 32'(lvl), 32'h0);
    rd(6'h01, d); chk(12, d, 32'h0);

    // table walk: R1 R3 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
      else begin
        rd(TBL[i].addr, d);
        chk(int'(TBL[i].req), d, TBL[i].data);
      end
    end

    // R4 rising edge, three-edge latency
    wr(6'h03, 32'h4);
    @(negedge clk); raw[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk(4, 32'(pend[3]), 32'h0);
    @(negedge clk);
    chk(4, 32'(pend[3]), 32'h1);
    rd(6'h21, d); chk(1, d & 32'h8, 32'h8);
    wr(6'h25, 32'd3);
    wait3();
    chk(4, 32'(pend[3]), 32'h0);   // steady high sets nothing

    // R4 falling edge
    raw[8] = 1'b1; wait3();
    wr(6'h08, 32'h5);
    chk(4, 32'(pend[8]), 32'h0);
    @(negedge clk); raw[8] = 1'b0;
    wait3();
    chk(4, 32'(pend[8]), 32'h1);

    // R11 hardware edge and software clear on the same edge
    @(negedge clk); raw[3] = 1'b0; wait3();
    @(negedge clk); raw[3] = 1'b1;
    repeat (2) @(negedge clk);
    we = 1'b1; addr = 6'h21; wdata = 32'h0000_0008;
    @(negedge clk); we = 1'b0;
    chk(11, 32'(pend[3]), 32'h1);

    // R5 / R8 high level with claim re-arm
    wr(6'h09, 32'h6);
    @(negedge clk); raw[9] = 1'b1; wait3();
    chk(5, 32'(pend[9]), 32'h1);
    wr(6'h25, 32'd9);
    chk(5, 32'(pend[9]), 32'h1);
    claim(5'd9);
    chk(8, 32'(pend[9]), 32'h1);
    raw[9] = 1'b0; wait3();
    chk(8, 32'(pend[9]), 32'h1);
    claim(5'd9);
    chk(8, 32'(pend[9]), 32'h0);

    // R5 low level
    wr(6'h0A, 32'h7);
    repeat (2) @(negedge clk);
    chk(5, 32'(pend[10]), 32'h1);
    raw[10] = 1'b1; wait3();
    claim(5'd10);
    chk(8, 32'(pend[10]), 32'h0);

    // R8 claim of an edge source
    wr(6'h07, 32'h1);
    wr(6'h24, 32'd7);
    chk(8, 32'(pend[7]), 32'h1);
    claim(5'd7);
    chk(8, 32'(pend[7]), 32'h0);

    // R7 delivery-mode filtering on level source 9 (input low)
    wr(6'h24, 32'd9);
    chk(7, 32'(pend[9]), 32'h0);
    msi = 1'b1;
    wr(6'h24, 32'd9);
    chk(7, 32'(pend[9]), 32'h1);
    wr(6'h25, 32'd9);
    chk(7, 32'(pend[9]), 32'h1);
    claim(5'd9);
    chk(7, 32'(pend[9]), 32'h0);
    msi = 1'b0;

    // R10 byte-reversed set by number
    wr(6'h05, 32'h4);
    wr(6'h28, 32'h0500_0000);
    chk(10, 32'(pend[5]), 32'h1);
    wr(6'h25, 32'd5);
    wr(6'h28, 32'h0000_0005);
    chk(10, 32'(pend[5]), 32'h0);

    // R6 reserved mode 2 is inert
    wr(6'h0B, 32'h2);
    wr(6'h26, 32'd11);
    wr(6'h24, 32'd11);
    @(negedge clk); raw[11] = 1'b1; wait3();
    chk(6, 32'(pend[11]), 32'h0);
    chk(6, 32'(en[11]), 32'h0);

    // R9 bitmap and number bounds
    for (int s = 1; s <= NS; s++) wr(6'(s), 32'h1);
    wr(6'h22, 32'hFFFF_FFFF);
    rd(6'h22, d); chk(9, d, 32'h001F_FFFE);
    wr(6'h21, 32'hFFFF_FFFF);
    wr(6'h24, 32'd21);
    wr(6'h24, 32'd0);
    rd(6'h20, d); chk(9, d, 32'h0);
    wr(6'h24, 32'd20);
    rd(6'h20, d); chk(9, d, 32'h0010_0000);

    // R2 no child domain: delegated write stores zero
    @(negedge clk); we2 = 1'b1; addr2 = 6'h02; wdata2 = 32'h0000_0405;
    @(negedge clk); we2 = 1'b0; #1;
    chk(2, rdata2, 32'h0);
    @(negedge clk); we2 = 1'b1; addr2 = 6'h02; wdata2 = 32'h0000_0004;
    @(negedge clk); we2 = 1'b0; #1;
    chk(2, rdata2, 32'h4);

    done = 1'b1;
    finish_run();
  end
endmodule